// File: doc/BRIEF.md
# Pipelined Accumulator Bank with Write Forwarding

This block keeps a bank of counters in a synchronous-read RAM whose read data passes through several output registers. Each accepted request adds an addend to the counter at the requested address and writes the sum back. Requests are accepted one per clock, in any address order, with no stall. Two addresses may be the same back to back, or only a few cycles apart. The RAM returns data several cycles after the read was launched, so a sum that is still on its way to the RAM would be missed. To cover this, the block keeps a short history of its own recent writes. Each history entry holds the address, the data and a valid flag. The newest matching entry replaces the stale RAM word as the operand of the add.

A second read path returns any counter's current value after a fixed delay. It uses the same forwarding, so it sees updates that have not reached the RAM yet. A clear input zeroes the whole bank. It does this by sending one zero write per address down the same pipeline, so the clear stays in order with the requests that are already in flight.

Top module: `accbank`

## Requirements
- R1: A request with `acc_en` high adds `acc_val` to the counter at `acc_addr`, and later reads of that address return the new total.
- R2: A request may be accepted every clock to the same address, and no update is lost.
- R3: Requests to one address separated by any number of cycles, including gaps shorter than the RAM read latency, and interleaved with other addresses, all add up correctly.
- R4: Sums wrap modulo 2^DATA_W: 0xFFFFFFF0 plus 0x20 gives 0x00000010 at the default width.
- R5: A read sampled with `rd_en` high gives `rd_valid` high exactly RAM_LAT+1 clock edges later, counting the edge that sampled it. `rd_data` includes every request sampled at that edge or earlier.
- R6: `busy` rises at the edge after `clr` is sampled high, and it stays high for exactly 2^ADDR_W cycles.
- R7: After a clear sweep, every counter reads zero.
- R8: Requests presented while `busy` is high are ignored.
- R9: While reset is applied and on the cycle after it, `busy` and `rd_valid` are low.
- R10: With `acc_en` low, the values on `acc_addr` and `acc_val` change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of control state (RAM contents are kept) |
| acc_en | input | 1 | Accumulation request strobe |
| acc_addr | input | ADDR_W | Counter selected by the request |
| acc_val | input | DATA_W | Addend |
| clr | input | 1 | Starts the zeroing sweep when not busy |
| busy | output | 1 | High while the sweep is issuing zero writes |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Counter to read |
| rd_valid | output | 1 | Read result present on `rd_data` |
| rd_data | output | DATA_W | Counter value returned by the read |

## Verification
The bench sends updates to one address with gaps of zero to five idle cycles, and it also alternates two addresses. A history that is one entry short, or whose search picks the oldest match instead of the newest, would drop or double-count some of these updates. It reads an address in the same cycle as a request to it, and it checks the exact cycle in which `rd_valid` appears. A read path that skipped the current-cycle write, or had a latency off by one, would return a stale total or a result at the wrong time. It also sends requests to an already-swept address throughout the clear, and it checks the exact length of `busy`. A design that accepted those requests would leave a nonzero total behind, and a sweep counter that was wrong would show up as a `busy` pulse of the wrong length. The last check adds a value that wraps the counter, to catch an add that saturates.

// File: rtl/accbank_pkg.sv
package accbank_pkg;

   // Kind of operation travelling down the update pipeline.
   // OP_IDLE must encode as zero: pipeline reset relies on it.
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_ADD  = 2'd1,
      OP_ZERO = 2'd2
   } op_kind_e;

   localparam int unsigned OP_KIND_W = 2;

endpackage

// File: rtl/accbank_dly.sv
// Fixed-length register chain with synchronous reset to zero.
module accbank_dly #(
   parameter int unsigned W = 8,
   parameter int unsigned N = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [N-1:0][W-1:0] chain_q;

   for (genvar gi = 0; gi < N; gi++) begin : g_stage
      logic [W-1:0] src;
      if (gi == 0) begin : g_head
         assign src = d;
      end else begin : g_body
         assign src = chain_q[gi-1];
      end
      always_ff @(posedge clk) begin
         if (rst) chain_q[gi] <= '0;
         else     chain_q[gi] <= src;
      end
   end

   assign q = chain_q[N-1];

endmodule

// File: rtl/accbank_ram.sv
// One write port and two synchronous read ports. Reads return the word held
// before a same-edge write. Read data passes through RD_LAT registers in total.
module accbank_ram #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RD_LAT = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [ADDR_W-1:0] ra_a,
   output logic [DATA_W-1:0] qa,
   input  logic [ADDR_W-1:0] ra_b,
   output logic [DATA_W-1:0] qb
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] core_a_q, core_b_q;

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   always_ff @(posedge clk) begin
      core_a_q <= mem[ra_a];
      core_b_q <= mem[ra_b];
   end

   if (RD_LAT > 1) begin : g_outreg
      accbank_dly #(.W(2*DATA_W), .N(RD_LAT-1)) u_out (
         .clk (clk),
         .rst (rst),
         .d   ({core_a_q, core_b_q}),
         .q   ({qa, qb})
      );
   end else begin : g_noreg
      logic unused_rst;
      assign unused_rst = rst;
      assign qa = core_a_q;
      assign qb = core_b_q;
   end

endmodule

// File: rtl/accbank_hist.sv
// Shift register of the last DEPTH writes; entry 0 is the newest.
module accbank_hist #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_vld,
   input  logic [ADDR_W-1:0]            in_addr,
   input  logic [DATA_W-1:0]            in_data,
   output logic [DEPTH-1:0]             hv,
   output logic [DEPTH-1:0][ADDR_W-1:0] ha,
   output logic [DEPTH-1:0][DATA_W-1:0] hd
);

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      if (gi == 0) begin : g_newest
         always_ff @(posedge clk) begin
            if (rst) hv[gi] <= 1'b0;
            else     hv[gi] <= in_vld;
            ha[gi] <= in_addr;
            hd[gi] <= in_data;
         end
      end else begin : g_older
         always_ff @(posedge clk) begin
            if (rst) hv[gi] <= 1'b0;
            else     hv[gi] <= hv[gi-1];
            ha[gi] <= ha[gi-1];
            hd[gi] <= hd[gi-1];
         end
      end
   end

endmodule

// File: rtl/accbank_fwd.sv
// Picks the lowest-index valid entry whose tag matches key, else ram_q.
module accbank_fwd #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N      = 3
) (
   input  logic [ADDR_W-1:0]        key,
   input  logic [DATA_W-1:0]        ram_q,
   input  logic [N-1:0]             ev,
   input  logic [N-1:0][ADDR_W-1:0] ea,
   input  logic [N-1:0][DATA_W-1:0] ed,
   output logic [DATA_W-1:0]        q
);

   always_comb begin
      q = ram_q;
      for (int i = N - 1; i >= 0; i--) begin
         if (ev[i] && (ea[i] == key)) q = ed[i];
      end
   end

endmodule

// File: rtl/accbank.sv
module accbank
   import accbank_pkg::*;
#(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned RAM_LAT = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_en,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_val,
   input  logic              clr,
   output logic              busy,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned ST_W  = OP_KIND_W + ADDR_W + DATA_W;
   localparam int unsigned RP_W  = 1 + ADDR_W;
   localparam int unsigned NFWD  = RAM_LAT + 1;
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   // elaboration-time parameter checks
   if (RAM_LAT < 1) begin : g_bad_lat
      $error("accbank: RAM_LAT must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("accbank: ADDR_W must lie in 1..16");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("accbank: DATA_W must be at least 1");
   end

   // ---------------- clear sweep ----------------
   logic [ADDR_W-1:0] sweep_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy      <= 1'b0;
         sweep_cnt <= '0;
      end else if (busy) begin
         sweep_cnt <= sweep_cnt + 1'b1;
         if (sweep_cnt == LAST_ADDR) busy <= 1'b0;
      end else if (clr) begin
         busy      <= 1'b1;
         sweep_cnt <= '0;
      end
   end

   // ---------------- issue stage ----------------
   op_kind_e          k0;
   logic [ADDR_W-1:0] a0;
   logic [DATA_W-1:0] v0;

   always_comb begin
      k0 = OP_IDLE;
      a0 = acc_addr;
      v0 = acc_val;
      if (busy) begin
         k0 = OP_ZERO;
         a0 = sweep_cnt;
         v0 = '0;
      end else if (acc_en && !clr) begin
         k0 = OP_ADD;
      end
   end

   // ---------------- update pipeline ----------------
   logic [ST_W-1:0]   st_out;
   op_kind_e          kL;
   logic [ADDR_W-1:0] aL;
   logic [DATA_W-1:0] vL;

   accbank_dly #(.W(ST_W), .N(RAM_LAT)) u_stpipe (
      .clk (clk),
      .rst (rst),
      .d   ({k0, a0, v0}),
      .q   (st_out)
   );

   assign kL = op_kind_e'(st_out[ST_W-1 -: OP_KIND_W]);
   assign aL = st_out[DATA_W +: ADDR_W];
   assign vL = st_out[DATA_W-1:0];

   // ---------------- read pipeline ----------------
   logic [RP_W-1:0]   rp_out;
   logic              rvL;
   logic [ADDR_W-1:0] raL;

   accbank_dly #(.W(RP_W), .N(RAM_LAT)) u_rdpipe (
      .clk (clk),
      .rst (rst),
      .d   ({rd_en, rd_addr}),
      .q   (rp_out)
   );

   assign rvL = rp_out[RP_W-1];
   assign raL = rp_out[ADDR_W-1:0];

   // ---------------- RAM ----------------
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] ram_upd_q, ram_rd_q;

   accbank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RAM_LAT)) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en),
      .wa   (aL),
      .wd   (wr_data),
      .ra_a (a0),
      .qa   (ram_upd_q),
      .ra_b (rd_addr),
      .qb   (ram_rd_q)
   );

   // ---------------- write history ----------------
   logic [RAM_LAT-1:0]             hv;
   logic [RAM_LAT-1:0][ADDR_W-1:0] ha;
   logic [RAM_LAT-1:0][DATA_W-1:0] hd;

   accbank_hist #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RAM_LAT)) u_hist (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (wr_en),
      .in_addr (aL),
      .in_data (wr_data),
      .hv      (hv),
      .ha      (ha),
      .hd      (hd)
   );

   // ---------------- compute stage ----------------
   logic [DATA_W-1:0] opnd;

   accbank_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(RAM_LAT)) u_fwd_upd (
      .key   (aL),
      .ram_q (ram_upd_q),
      .ev    (hv),
      .ea    (ha),
      .ed    (hd),
      .q     (opnd)
   );

   assign wr_en   = (kL != OP_IDLE);
   assign wr_data = (kL == OP_ZERO) ? '0 : (opnd + vL);

   // ---------------- read result ----------------
   logic [NFWD-1:0]             rev;
   logic [NFWD-1:0][ADDR_W-1:0] rea;
   logic [NFWD-1:0][DATA_W-1:0] red;
   logic [DATA_W-1:0]           rd_fwd;

   assign rev = {hv, wr_en};
   assign rea = {ha, aL};
   assign red = {hd, wr_data};

   accbank_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NFWD)) u_fwd_rd (
      .key   (raL),
      .ram_q (ram_rd_q),
      .ev    (rev),
      .ea    (rea),
      .ed    (red),
      .q     (rd_fwd)
   );

   always_ff @(posedge clk) begin
      if (rst) rd_valid <= 1'b0;
      else     rd_valid <= rvL;
      rd_data <= rd_fwd;
   end

endmodule

// File: rtl/accbank_chk.sv
module accbank_chk #(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned RAM_LAT = 3
) (
   input logic clk,
   input logic rst,
   input logic clr,
   input logic busy,
   input logic rd_en,
   input logic rd_valid
);

   localparam int unsigned RUN_W = ADDR_W + 2;
   localparam logic [RUN_W-1:0] SWEEP_LEN = RUN_W'(1) << ADDR_W;

   logic [RUN_W-1:0]   busy_run;
   logic [RAM_LAT:0]   rd_sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_run <= '0;
         rd_sh    <= '0;
      end else begin
         busy_run <= busy ? busy_run + 1'b1 : '0;
         rd_sh    <= {rd_sh[RAM_LAT-1:0], rd_en};
      end
   end

   // R6
   clr_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(clr));

   // R6
   busy_run_lim_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> (busy_run < SWEEP_LEN));

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (busy_run == SWEEP_LEN));

   // R5
   rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid == rd_sh[RAM_LAT]);

   // R9
   rst_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (!busy && !rd_valid));

endmodule

bind accbank accbank_chk #(.ADDR_W(ADDR_W), .RAM_LAT(RAM_LAT)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .clr      (clr),
   .busy     (busy),
   .rd_en    (rd_en),
   .rd_valid (rd_valid)
);

// File: tb/accbank_tb.sv
`timescale 1ns/1ps
module accbank_tb;

   localparam int AW    = 9;
   localparam int DW    = 32;
   localparam int L     = 3;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          acc_en = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [DW-1:0] acc_val = '0;
   logic          clr = 1'b0;
   logic          busy;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;

   always #2.5 clk = ~clk;

   accbank #(.ADDR_W(AW), .DATA_W(DW), .RAM_LAT(L)) u_dut (
      .clk(clk), .rst(rst), .acc_en(acc_en), .acc_addr(acc_addr),
      .acc_val(acc_val), .clr(clr), .busy(busy), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int total = 0;
   int bad   = 0;
   logic [DW-1:0] model [DEPTH];
   logic [DW-1:0] expq [$];
   string         tagq [$];

   task automatic check(input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock of stimulus; inputs change at the falling edge
   task automatic cyc(input bit en, input logic [AW-1:0] a, input logic [DW-1:0] v,
                      input bit upd, input bit ren, input logic [AW-1:0] ra,
                      input string tag, input bit c);
      acc_en = en; acc_addr = a; acc_val = v;
      rd_en = ren; rd_addr = ra; clr = c;
      if (en && upd) model[a] = model[a] + v;
      if (ren) begin
         expq.push_back(model[ra]);
         tagq.push_back(tag);
      end
      @(negedge clk);
      acc_en = 1'b0; rd_en = 1'b0; clr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, 0, '0, "", 0);
   endtask

   task automatic acc(input logic [AW-1:0] a, input logic [DW-1:0] v);
      cyc(1, a, v, 1, 0, '0, "", 0);
   endtask

   task automatic rdq(input logic [AW-1:0] a, input string tag);
      cyc(0, '0, '0, 0, 1, a, tag, 0);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && rd_valid) begin
         if (expq.size() == 0) begin
            total++; bad++;
            $display("FAIL R5 actual=rd_valid=1 expected=no read pending");
         end else begin
            logic [DW-1:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, rd_data, e);
         end
      end
   end

   task automatic sweep(input bit chk_busy);
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      cyc(0, '0, '0, 0, 0, '0, "", 1);
      if (chk_busy) check("R6 busy after clr", {31'd0, busy}, 32'd1);
      for (int k = 1; k < DEPTH; k++) cyc(1, '0, 32'h11, 0, 0, '0, "", 0); // R8
      if (chk_busy) check("R6 busy last cycle", {31'd0, busy}, 32'd1);
      idle(1);
      if (chk_busy) check("R6 busy end", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      check("R9 busy in reset", {31'd0, busy}, 32'd0);
      check("R9 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R9 busy after reset", {31'd0, busy}, 32'd0);

      // R6 R7 R8: sweep with ignored requests to address 0
      sweep(1);
      rdq(0, "R8 addr0 after ignored requests");
      rdq(5, "R7");
      rdq(9'd511, "R7 last addr");
      rdq(100, "R7");
      idle(L + 2);

      // R1
      acc(10, 32'd100); idle(5);
      acc(20, 32'h1234); idle(5);
      rdq(10, "R1"); rdq(20, "R1");
      acc(10, 32'd1); idle(5);
      rdq(10, "R1 second add");

      // R2: back-to-back to one address, read in the last request cycle
      for (int k = 0; k < 11; k++) acc(30, 32'(k + 1));
      cyc(1, 30, 32'd500, 1, 1, 30, "R2 R5 same-cycle read", 0);
      rdq(30, "R2");

      // R3: gaps of 0..5 idle cycles
      for (int g = 0; g < 6; g++) begin
         acc(40, 32'(g * 3 + 1));
         idle(g);
         rdq(40, "R3 gap");
      end
      for (int k = 0; k < 8; k++) acc(9'(41 + (k % 2)), 32'(k + 7));
      rdq(41, "R3 interleave"); rdq(42, "R3 interleave");

      // R4
      acc(50, 32'hFFFF_FFF0); acc(50, 32'h20);
      rdq(50, "R4 wrap");

      // R10
      cyc(0, 50, 32'h55, 0, 0, '0, "", 0);
      cyc(0, 50, 32'h77, 0, 0, '0, "", 0);
      rdq(50, "R10 disabled request");

      // R5: exact latency
      idle(L + 3);
      rdq(60, "R5 value");
      for (int k = 0; k < L; k++) begin
         check("R5 rd_valid early", {31'd0, rd_valid}, 32'd0);
         idle(1);
      end
      check("R5 rd_valid on time", {31'd0, rd_valid}, 32'd1);

      // mixed traffic: request and read each cycle
      lfsr = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
         logic [AW-1:0] a, r;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = (lfsr[3:0] == 4'hF) ? 9'd511 : 9'(lfsr[2:0]);
         r = (lfsr[7:4] == 4'hF) ? 9'd511 : 9'(lfsr[6:4]);
         cyc(lfsr[8] | lfsr[9], a, 32'(lfsr) * 32'd977, 1, 1, r, "R3 mixed", 0);
      end
      idle(L + 2);

      // second clear after traffic
      sweep(0);
      rdq(9'd511, "R7 after traffic");
      rdq(7, "R7 after traffic");
      idle(L + 4);
      check("R5 no pending reads", 32'(expq.size()), 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule